// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block merges nine reset requests into one active-high system reset. The nine requests are power-on, a filtered external pin, a software reset instruction, a watchdog timeout, brown-out, configuration mismatch, trap conflict, illegal opcode and use of an uninitialized working register. The system reset stays asserted for a fixed tail after the last request goes away, so every downstream register sees a reset that is long enough.

A 16-bit cause register records which request, or which set of requests, caused the reset. Each cause flag is sticky. It survives the reset it reports and stays set through later non-power-on resets, so software reads the register after a restart and then clears the flags. Power-on loads a fixed pattern into the register. Software writes change the flags only and never start a reset.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While any level request (software, watchdog, brown-out, configuration mismatch, trap conflict, illegal opcode, uninitialized register) is high, `sys_rst` is high in the same cycle. A qualified pin request and power-on also assert it.
- R2: While power-on is in effect, and in the first cycle after it ends, `reg_rdata` reads 0x0003: bit 0 (power-on) and bit 1 (brown-out) are set and every other bit is clear, bit 6 included.
- R3: Each non-power-on request sets its own flag at the clock edge where it is sampled: brown-out bit 1, watchdog bit 4, software bit 5, pin bit 7, configuration mismatch bit 8, uninitialized register bit 9, illegal opcode bit 14, trap conflict bit 15.
- R4: Requests that are active in the same cycle all set their flags together.
- R5: Outside power-on, a flag that is set stays set until software writes it to 0. A new request only adds its own flag.
- R6: A write (`reg_we` high) loads `reg_wdata` into bits 0, 1, 4–9, 14 and 15. Bit 6 is a plain read/write bit. Bits 2, 3 and 10–13 always read 0. A write never asserts `sys_rst`.
- R7: If a write and a hardware request hit the same flag in the same cycle, the flag ends up set.
- R8: `pin_req` counts as a request only after 4 consecutive high samples. A pulse of 3 samples leaves `sys_rst` low and bit 7 clear.
- R9: After the last request is released, `sys_rst` stays high for exactly 16 more cycles.
- R10: `por_req` asserts `sys_rst` at once, without waiting for a clock. Power-on stays in effect until the second clock edge after `por_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, asynchronous assert |
| pin_req | input | 1 | External reset pin, before the filter |
| swr_req | input | 1 | Software reset instruction |
| wdt_req | input | 1 | Watchdog timeout |
| bor_req | input | 1 | Brown-out detected |
| cfg_req | input | 1 | Configuration word mismatch |
| trap_req | input | 1 | Trap conflict |
| opc_req | input | 1 | Illegal opcode |
| uwr_req | input | 1 | Uninitialized working register use |
| reg_we | input | 1 | Cause register write enable |
| reg_wdata | input | 16 | Cause register write data |
| reg_rdata | output | 16 | Cause register read data |
| sys_rst | output | 1 | System reset, active high |

## Verification
The bench builds the block with its default values: a 4-sample pin filter, a 16-cycle tail and a 2-stage power-on synchronizer. At these values the filter edge case (3 samples against 4) and the complete tail of every reset can be checked within a few dozen cycles each. A behavioural model runs beside the design and tracks the filter run length, the tail counter and the flags as plain integers. This covers the cases that build on each other: sticky flags carried across several resets, a write colliding with a hardware request, and a second power-on that wipes flags software had set.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int REG_W = 16;

    localparam int B_POR  = 0;
    localparam int B_BOR  = 1;
    localparam int B_WDT  = 4;
    localparam int B_SWR  = 5;
    localparam int B_SWEN = 6;
    localparam int B_PIN  = 7;
    localparam int B_CFG  = 8;
    localparam int B_UWR  = 9;
    localparam int B_OPC  = 14;
    localparam int B_TRAP = 15;

    localparam logic [REG_W-1:0] POR_PATTERN = 16'h0003;
    localparam logic [REG_W-1:0] WR_MASK     = 16'hC3F3;

    typedef struct packed {
        logic trap;
        logic opc;
        logic uwr;
        logic cfg;
        logic pin;
        logic swr;
        logic wdt;
        logic bor;
        logic por;
    } rst_src_t;

    function automatic logic [REG_W-1:0] cause_mask(rst_src_t s);
        logic [REG_W-1:0] m;
        m         = '0;
        m[B_POR]  = s.por;
        m[B_BOR]  = s.bor;
        m[B_WDT]  = s.wdt;
        m[B_SWR]  = s.swr;
        m[B_PIN]  = s.pin;
        m[B_CFG]  = s.cfg;
        m[B_UWR]  = s.uwr;
        m[B_OPC]  = s.opc;
        m[B_TRAP] = s.trap;
        return m;
    endfunction

endpackage

// File: rtl/rstc_por_sync.sv
module rstc_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_async,
    output logic por_int
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge por_async) begin
                if (por_async) sr <= 1'b1;
                else           sr <= 1'b0;
            end
        end else begin : g_chain
            always_ff @(posedge clk or posedge por_async) begin
                if (por_async) sr <= '1;
                else           sr <= {sr[STAGES-2:0], 1'b0};
            end
        end
    endgenerate

    assign por_int = sr[STAGES-1];
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_raw,
    output logic pin_ok
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (clr || !pin_raw) run <= '0;
        else if (run != FULL) run <= run + 1'b1;
    end

    assign pin_ok = (run == FULL);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic trig,
    output logic hold_active
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (trig)          cnt <= LOAD;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign hold_active = (cnt != 0);
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic             clk,
    input  logic             por_int,
    input  rst_src_t         src,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] cur;
    logic [REG_W-1:0] nxt;

    always_comb begin
        nxt = we ? (wdata & WR_MASK) : cur;
        nxt = nxt | cause_mask(src);
    end

    always_ff @(posedge clk) begin
        if (por_int) cur <= POR_PATTERN;
        else         cur <= nxt;
    end

    assign rdata = cur;
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int FILT_LEN  = 4,
    parameter int HOLD_CYC  = 16,
    parameter int POR_STAGE = 2
) (
    input  logic        clk,
    input  logic        por_req,
    input  logic        pin_req,
    input  logic        swr_req,
    input  logic        wdt_req,
    input  logic        bor_req,
    input  logic        cfg_req,
    input  logic        trap_req,
    input  logic        opc_req,
    input  logic        uwr_req,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sys_rst
);
    logic       por_int;
    logic       pin_ok;
    logic       hold_active;
    logic       any_req;
    logic [6:0] lvl_src;
    rst_src_t   src;

    rstc_por_sync #(.STAGES(POR_STAGE)) u_por (
        .clk       (clk),
        .por_async (por_req),
        .por_int   (por_int)
    );

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
        .clk     (clk),
        .clr     (por_int),
        .pin_raw (pin_req),
        .pin_ok  (pin_ok)
    );

    assign lvl_src = {trap_req, opc_req, uwr_req, cfg_req, swr_req, wdt_req, bor_req};

    always_comb begin
        src      = '0;
        src.por  = por_int;
        src.pin  = pin_ok;
        src.bor  = lvl_src[0];
        src.wdt  = lvl_src[1];
        src.swr  = lvl_src[2];
        src.cfg  = lvl_src[3];
        src.uwr  = lvl_src[4];
        src.opc  = lvl_src[5];
        src.trap = lvl_src[6];
    end

    assign any_req = |src;

    rstc_stretch #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk         (clk),
        .trig        (any_req),
        .hold_active (hold_active)
    );

    rstc_cause_reg u_cause (
        .clk     (clk),
        .por_int (por_int),
        .src     (src),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata)
    );

    assign sys_rst = por_int | any_req | hold_active;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int HOLD_CYC = 16
) (
    input logic        clk,
    input logic        por_int,
    input logic        any_req,
    input logic [6:0]  lvl_src,
    input logic        pin_req,
    input logic        sys_rst,
    input logic        reg_we,
    input logic [15:0] reg_rdata
);
    localparam int QW = $clog2(HOLD_CYC + 2) + 1;
    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (por_int || any_req)            quiet <= QW'(1);
        else if (quiet <= QW'(HOLD_CYC))   quiet <= quiet + 1'b1;
    end

    a_r1_level_asserts: assert property (@(posedge clk) disable iff (por_int)
        (|lvl_src) |-> sys_rst);

    a_r2_por_pattern: assert property (@(posedge clk) disable iff (por_int)
        $fell(por_int) |-> (reg_rdata == 16'h0003));

    a_r5_sticky: assert property (@(posedge clk) disable iff (por_int)
        !reg_we |=> ((reg_rdata & $past(reg_rdata)) == $past(reg_rdata)));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (por_int)
        (reg_rdata & 16'h3C0C) == 16'h0000);

    a_r6_write_quiet: assert property (@(posedge clk) disable iff (por_int)
        (!sys_rst && !(|lvl_src) && !pin_req) |=> (!sys_rst || (|lvl_src)));

    a_r9_tail_high: assert property (@(posedge clk) disable iff (por_int)
        (!any_req && quiet >= QW'(1) && quiet <= QW'(HOLD_CYC)) |-> sys_rst);

    a_r9_tail_ends: assert property (@(posedge clk) disable iff (por_int)
        (!any_req && quiet > QW'(HOLD_CYC)) |-> !sys_rst);
endmodule

bind reset_cause_ctrl rstc_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk       (clk),
    .por_int   (por_int),
    .any_req   (any_req),
    .lvl_src   (lvl_src),
    .pin_req   (pin_req),
    .sys_rst   (sys_rst),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_reset_cause_ctrl.sv
`timescale 1ns/1ps
module sim_reset_cause_ctrl;
    localparam int FILT = 4;
    localparam int HOLD = 16;

    logic clk = 1'b0;
    logic por_req = 1'b0, pin_req = 1'b0, swr_req = 1'b0, wdt_req = 1'b0, bor_req = 1'b0;
    logic cfg_req = 1'b0, trap_req = 1'b0, opc_req = 1'b0, uwr_req = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic sys_rst;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    reset_cause_ctrl u0 (
        .clk(clk), .por_req(por_req), .pin_req(pin_req), .swr_req(swr_req),
        .wdt_req(wdt_req), .bor_req(bor_req), .cfg_req(cfg_req), .trap_req(trap_req),
        .opc_req(opc_req), .uwr_req(uwr_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst(sys_rst)
    );

    // behavioural reference
    int m_s0 = 0, m_s1 = 0, m_run = 0, m_hold = 0;
    logic [15:0] m_cause = 16'h0;

    function automatic logic m_level();
        return swr_req | wdt_req | bor_req | cfg_req | trap_req | opc_req | uwr_req;
    endfunction

    always @(posedge clk) begin
        logic pi, pf, act;
        logic [15:0] c;
        pi  = (m_s1 != 0) || por_req;
        pf  = (m_run == FILT);
        act = pi || pf || m_level();
        if (pi) c = 16'h0003;
        else begin
            c = reg_we ? (reg_wdata & 16'hC3F3) : m_cause;
            if (bor_req)  c[1]  = 1'b1;
            if (wdt_req)  c[4]  = 1'b1;
            if (swr_req)  c[5]  = 1'b1;
            if (pf)       c[7]  = 1'b1;
            if (cfg_req)  c[8]  = 1'b1;
            if (uwr_req)  c[9]  = 1'b1;
            if (opc_req)  c[14] = 1'b1;
            if (trap_req) c[15] = 1'b1;
        end
        m_cause = c;
        if (act) m_hold = HOLD;
        else if (m_hold > 0) m_hold = m_hold - 1;
        if (pi || !pin_req) m_run = 0;
        else if (m_run < FILT) m_run = m_run + 1;
        if (por_req) begin m_s0 = 1; m_s1 = 1; end
        else begin m_s1 = m_s0; m_s0 = 0; end
    end

    always @(negedge clk) begin
        logic exp_rst;
        exp_rst = (m_s1 != 0) || por_req || (m_run == FILT) || m_level() || (m_hold > 0);
        n_cmp++;
        if (sys_rst !== exp_rst) begin
            n_bad++;
            $display("FAIL R1/R9 model sys_rst act=%b exp=%b t=%0t", sys_rst, exp_rst, $time);
        end
        n_cmp++;
        if (reg_rdata !== m_cause) begin
            n_bad++;
            $display("FAIL R3/R5 model rdata act=%h exp=%h t=%0t", reg_rdata, m_cause, $time);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (HOLD + 4) tick();
    endtask

    task automatic pulse(input int which);
        case (which)
            0: bor_req = 1'b1;
            1: wdt_req = 1'b1;
            2: swr_req = 1'b1;
            3: cfg_req = 1'b1;
            4: uwr_req = 1'b1;
            5: opc_req = 1'b1;
            default: trap_req = 1'b1;
        endcase
        tick();
        {bor_req, wdt_req, swr_req, cfg_req, uwr_req, opc_req, trap_req} = '0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] bitpos [7];
        int hi;
        bitpos[0] = 16'h0002; bitpos[1] = 16'h0010; bitpos[2] = 16'h0020;
        bitpos[3] = 16'h0100; bitpos[4] = 16'h0200; bitpos[5] = 16'h4000;
        bitpos[6] = 16'h8000;

        // R10: asynchronous assertion
        #1 por_req = 1'b1;
        #0.5 chk("R10 async assert", {15'h0, sys_rst}, 16'h1);
        tick(); tick(); tick();
        por_req = 1'b0;
        tick();
        chk("R10 still in reset one edge after release", {15'h0, sys_rst}, 16'h1);
        tick();
        @(negedge clk);
        chk("R2 power-on pattern", reg_rdata, 16'h0003);
        #1 settle();
        chk("R9 quiet after tail", {15'h0, sys_rst}, 16'h0);

        // R6: writes
        wr(16'hFFFF);
        @(negedge clk);
        chk("R6 writable bits", reg_rdata, 16'hC3F3);
        chk("R6 write no reset", {15'h0, sys_rst}, 16'h0);
        #1 tick(); tick();
        chk("R6 still no reset", {15'h0, sys_rst}, 16'h0);
        wr(16'h0040);
        chk("R6 bit6 read/write", reg_rdata, 16'h0040);
        wr(16'h0000);
        chk("R6 clear", reg_rdata, 16'h0000);

        // R1 + R9: watchdog pulse and tail length
        wdt_req = 1'b1;
        @(negedge clk);
        chk("R1 same-cycle assert", {15'h0, sys_rst}, 16'h1);
        #1 tick();
        wdt_req = 1'b0;
        hi = 0;
        for (int i = 0; i < HOLD + 6; i++) begin
            @(negedge clk);
            if (sys_rst) hi++;
        end
        chk("R9 tail length", 16'(hi), 16'(HOLD));
        chk("R3 watchdog flag", reg_rdata, 16'h0010);

        // R5: sticky across a second reset
        #1 pulse(2);
        settle();
        chk("R5 sticky plus software", reg_rdata, 16'h0030);

        // R3: each level source alone
        for (int k = 0; k < 7; k++) begin
            wr(16'h0000);
            pulse(k);
            settle();
            chk("R3 single source flag", reg_rdata, bitpos[k]);
        end

        // R4: simultaneous
        wr(16'h0000);
        wdt_req = 1'b1; trap_req = 1'b1; cfg_req = 1'b1;
        tick();
        wdt_req = 1'b0; trap_req = 1'b0; cfg_req = 1'b0;
        settle();
        chk("R4 simultaneous flags", reg_rdata, 16'h8110);

        // R8: pin filter
        wr(16'h0000);
        pin_req = 1'b1;
        repeat (FILT - 1) tick();
        pin_req = 1'b0;
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (sys_rst) hi++;
        end
        chk("R8 short pin pulse ignored", 16'(hi), 16'h0);
        chk("R8 short pin no flag", reg_rdata, 16'h0000);
        #1 pin_req = 1'b1;
        repeat (FILT) tick();
        @(negedge clk);
        chk("R8 pin qualified", {15'h0, sys_rst}, 16'h1);
        #1 pin_req = 1'b0;
        settle();
        chk("R8 pin flag", reg_rdata, 16'h0080);

        // R7: write collides with hardware set
        wr(16'h0020);
        reg_we = 1'b1; reg_wdata = 16'h0000; wdt_req = 1'b1;
        tick();
        reg_we = 1'b0; wdt_req = 1'b0;
        chk("R7 hardware wins", reg_rdata, 16'h0010);
        settle();

        // R2: second power-on wipes software bits
        wr(16'hC3F3);
        por_req = 1'b1;
        tick(); tick();
        por_req = 1'b0;
        tick(); tick();
        @(negedge clk);
        chk("R2 re-power pattern", reg_rdata, 16'h0003);
        #1 settle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule